// File: doc/BRIEF.md
# Parallel Sampling-Converter Read Sequencer

This block sits on the host side of a 12-bit sampling converter that has a parallel output. It drives the converter's chip select, read, convert-start and power-down lines. It watches the converter's BUSY line, which is low while a conversion runs. When BUSY returns high, it captures the 12-bit data bus. Each conversion is requested through a start handshake. Each result leaves through a valid/ready stream port. The block widens the result to a fixed output width, as unsigned or as two's complement, according to the input range latched with the request.

There are two capture styles. In the first, chip select and read stay low for the whole transaction, and the data bus is taken in the cycle where BUSY is first seen high. In the second, chip select stays low but read stays high during the conversion. Read is then pulsed low for an access interval after BUSY rises, and the bus is taken at the end of that pulse. Every analog timing minimum is a nanosecond parameter that the block converts to whole clock cycles by rounding up. These minimums are chip-select setup, convert-start low width, wake-up after power-down, read access and the acquisition gap. A BUSY watchdog stops the block from waiting forever on a dead converter.

Back-pressure rules are as follows. A result, once valid, keeps its value until `res_ready_i` is seen high on a clock edge. No new conversion is accepted while a result is waiting, so the block never drops or overwrites a result. A start is taken on an edge where `start_valid_i` and `start_ready_o` are both high.

Top module: `adc_read_seq`

## Requirements
- R1: After reset, the power-down line is high, chip select, read and convert-start are high, `res_valid_o` and `err_o` are 0, and `start_ready_o` stays low for the wake-up interval (ceil(350 ns / clock) cycles) before it first rises.
- R2: Chip select goes low on the edge that accepts a start, and it stays low for at least ceil(20 ns / clock) cycles before convert-start falls.
- R3: Convert-start is low for exactly ceil(40 ns / clock) cycles per conversion, which must not exceed floor(120 ns / clock). It falls only once per accepted start.
- R4: With `mode_i` = 0 (capture on BUSY), read stays low together with chip select. The result is the data bus value in the first cycle in which BUSY is high after it was seen low.
- R5: With `mode_i` = 1 (strobed read), read stays high during the conversion. After BUSY rises, read is low for ceil(170 ns / clock) cycles. The bus is captured in the last of those cycles, and read then returns high.
- R6: After a capture, at least ceil(200 ns / clock) cycles pass before the next convert-start falls, and `start_ready_o` stays low during that gap.
- R7: With `bipolar_i` = 0, the 12-bit code is zero-extended to 16 bits. With `bipolar_i` = 1, it is sign-extended from bit 11 (0x800 gives 0xF800, 0x7FF gives 0x07FF).
- R8: While `res_valid_o` is high and `res_ready_i` is low, `res_valid_o` and `res_data_o` hold, and `start_ready_o` is low.
- R9: While `sleep_req_i` is high with the sequencer idle, the power-down line is low and `start_ready_o` is low. After it drops, the power-down line is high for at least the wake-up interval before convert-start falls.
- R10: If BUSY has not risen ceil(2600 ns / clock) cycles after convert-start is released, `err_o` becomes 1 and stays 1 until reset, no result is produced, and chip select returns high.
- R11: `mode_i` and `bipolar_i` are sampled only on the accepting edge. Changes during a conversion do not affect that conversion's strobes or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid_i | input | 1 | Conversion request |
| start_ready_o | output | 1 | Request can be taken this cycle |
| mode_i | input | 1 | 0 = capture on BUSY rise, 1 = strobed read |
| bipolar_i | input | 1 | 1 = two's complement range |
| sleep_req_i | input | 1 | Power the converter down while idle |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Consumer takes the result |
| res_data_o | output | 16 | Widened result |
| err_o | output | 1 | Sticky BUSY timeout flag |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_rd_n_o | output | 1 | Converter read, active low |
| adc_convst_n_o | output | 1 | Convert start, falling edge starts |
| adc_shdn_n_o | output | 1 | Converter power-down, active low |
| adc_busy_n_i | input | 1 | Converter BUSY, low while converting |
| adc_data_i | input | 12 | Converter data bus |

## Verification
The bench models the converter. Its bus drives the previous code until BUSY rises, and it drives nothing while read is high. A design that captures a cycle early, or strobes read too soon in strobed mode, would therefore return the stale code. Codes are placed at the range limits (0x000, 0xFFF, 0x800, 0x7FF) so that a wrong sign extension shows up in the upper four bits. Three further cases are targeted. A start that arrives right after power-down is released catches a design that counts the wake-up delay from the wrong point. A held result combined with a pending request catches a design that overwrites the result or accepts the start early. A silent converter catches a design that hangs, or whose error flag clears itself.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CLOW, ST_WAITB, ST_RDLOW, ST_ACQ, ST_SLEEP, ST_WAKE
  } seq_state_e;

  typedef enum logic {
    CAP_ON_BUSY   = 1'b0,
    CAP_ON_STROBE = 1'b1
  } cap_mode_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int unsigned RAW_W = 12,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [RAW_W-1:0] raw_i,
  input  logic             bip_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o
);
  localparam int unsigned EXT_W = OUT_W - RAW_W;

  logic [OUT_W-1:0] widened;
  logic             valid_q;
  logic [OUT_W-1:0] data_q;

  generate
    if (EXT_W == 0) begin : g_same
      assign widened = raw_i;
    end else begin : g_ext
      logic fill;
      assign fill    = bip_i & raw_i[RAW_W-1];
      assign widened = {{EXT_W{fill}}, raw_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (push_i) begin
      valid_q <= 1'b1;
      data_q  <= widened;
    end else if (valid_q && out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  // R8: a stalled result keeps its value
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready_i) |=> (valid_q && $stable(data_q)));

  generate
    if (EXT_W > 0) begin : g_chk
      // R7: upper bits are either all zero or a copy of the code's top bit
      a_r7_ext_shape: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ((data_q[OUT_W-1:RAW_W] == '0) ||
                     (data_q[RAW_W-1] && (data_q[OUT_W-1:RAW_W] == '1))));
    end
  endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned CYC_CS     = 3,
  parameter int unsigned CYC_CL     = 5,
  parameter int unsigned CYC_CL_MAX = 15,
  parameter int unsigned CYC_RD     = 22,
  parameter int unsigned CYC_ACQ    = 25,
  parameter int unsigned CYC_WAKE   = 44,
  parameter int unsigned CYC_TO     = 325
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid_i,
  output logic             start_ready_o,
  input  logic             mode_i,
  input  logic             bip_i,
  input  logic             sleep_req_i,
  input  logic             hold_full_i,
  input  logic             busy_n_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             push_o,
  output logic             bip_o,
  output logic             err_o,
  output logic             cs_n_o,
  output logic             rd_n_o,
  output logic             convst_n_o,
  output logic             shdn_n_o
);
  seq_state_e state_q, state_d;
  cap_mode_e  mode_q;
  logic       bip_q, seen_low_q, err_q;
  logic       accept, set_err, busy_rise;

  assign busy_rise     = (state_q == ST_WAITB) && seen_low_q && busy_n_i;
  assign start_ready_o = (state_q == ST_IDLE) && !hold_full_i && !sleep_req_i;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    push_o     = 1'b0;
    set_err    = 1'b0;
    accept     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sleep_req_i) begin
          state_d = ST_SLEEP;
        end else if (start_valid_i && !hold_full_i) begin
          accept     = 1'b1;
          state_d    = ST_SETUP;
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(CYC_CS - 1);
        end
      end
      ST_SETUP: if (tmr_zero_i) begin
        state_d    = ST_CLOW;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(CYC_CL - 1);
      end
      ST_CLOW: if (tmr_zero_i) begin
        state_d    = ST_WAITB;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(CYC_TO - 1);
      end
      ST_WAITB: begin
        if (busy_rise) begin
          tmr_load_o = 1'b1;
          if (mode_q == CAP_ON_BUSY) begin
            push_o    = 1'b1;
            state_d   = ST_ACQ;
            tmr_val_o = CNT_W'(CYC_ACQ - 1);
          end else begin
            state_d   = ST_RDLOW;
            tmr_val_o = CNT_W'(CYC_RD - 1);
          end
        end else if (tmr_zero_i) begin
          set_err = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_RDLOW: if (tmr_zero_i) begin
        push_o     = 1'b1;
        state_d    = ST_ACQ;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(CYC_ACQ - 1);
      end
      ST_ACQ:   if (tmr_zero_i) state_d = ST_IDLE;
      ST_SLEEP: if (!sleep_req_i) begin
        state_d    = ST_WAKE;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(CYC_WAKE - 1);
      end
      ST_WAKE:  if (tmr_zero_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_WAKE;
      mode_q     <= CAP_ON_BUSY;
      bip_q      <= 1'b0;
      seen_low_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_q     <= cap_mode_e'(mode_i);
        bip_q      <= bip_i;
        seen_low_q <= 1'b0;
      end else if (((state_q == ST_CLOW) || (state_q == ST_WAITB)) && !busy_n_i) begin
        seen_low_q <= 1'b1;
      end
      if (set_err) err_q <= 1'b1;
    end
  end

  logic sel_active;
  assign sel_active = (state_q == ST_SETUP) || (state_q == ST_CLOW) ||
                      (state_q == ST_WAITB) || (state_q == ST_RDLOW);
  assign cs_n_o     = !sel_active;
  assign rd_n_o     = !((sel_active && (state_q != ST_RDLOW) && (mode_q == CAP_ON_BUSY)) ||
                        (state_q == ST_RDLOW));
  assign convst_n_o = (state_q != ST_CLOW);
  assign shdn_n_o   = (state_q != ST_SLEEP);
  assign bip_o      = bip_q;
  assign err_o      = err_q;

  // Interval counters observed by the properties below
  localparam logic [CNT_W-1:0] SAT = '1;
  logic [CNT_W-1:0] low_len_q, since_cap_q, since_wake_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len_q    <= '0;
      since_cap_q  <= SAT;
      since_wake_q <= '0;
    end else begin
      low_len_q    <= !convst_n_o ? ((low_len_q == SAT) ? SAT : low_len_q + 1'b1) : '0;
      since_cap_q  <= push_o ? '0 : ((since_cap_q == SAT) ? SAT : since_cap_q + 1'b1);
      since_wake_q <= !shdn_n_o ? '0 : ((since_wake_q == SAT) ? SAT : since_wake_q + 1'b1);
    end
  end

  // R2: chip select already low on the cycle before convert-start falls
  a_r2_cs_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n_o) |-> $past(!cs_n_o));
  // R3: released after the programmed width, inside the allowed window
  a_r3_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_n_o) |-> (low_len_q == CNT_W'(CYC_CL)) && (low_len_q <= CNT_W'(CYC_CL_MAX)));
  // R6: acquisition gap before the next start
  a_r6_acq_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n_o) |-> (since_cap_q >= CNT_W'(CYC_ACQ)));
  // R9: wake-up interval after power-down release (and after reset, R1)
  a_r9_wake_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n_o) |-> (since_wake_q >= CNT_W'(CYC_WAKE)));
  // R9: no selection while powered down
  a_r9_quiet_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_o |-> (cs_n_o && convst_n_o));
  // R10: error flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  // R8: no start offered while a result waits
  a_r8_no_start_full: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full_i |-> !start_ready_o);
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W          = 12,
  parameter int unsigned OUT_W           = 16,
  parameter int unsigned CLK_NS          = 8,
  parameter int unsigned CS_SETUP_NS     = 20,
  parameter int unsigned CONV_LOW_NS     = 40,
  parameter int unsigned CONV_LOW_MAX_NS = 120,
  parameter int unsigned RD_ACCESS_NS    = 170,
  parameter int unsigned ACQ_NS          = 200,
  parameter int unsigned WAKE_NS         = 350,
  parameter int unsigned BUSY_TO_NS      = 2600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid_i,
  output logic              start_ready_o,
  input  logic              mode_i,
  input  logic              bipolar_i,
  input  logic              sleep_req_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [OUT_W-1:0]  res_data_o,
  output logic              err_o,
  output logic              adc_cs_n_o,
  output logic              adc_rd_n_o,
  output logic              adc_convst_n_o,
  output logic              adc_shdn_n_o,
  input  logic              adc_busy_n_i,
  input  logic [DATA_W-1:0] adc_data_i
);
  localparam int unsigned CYC_CS     = ns_to_cyc(CS_SETUP_NS, CLK_NS);
  localparam int unsigned CYC_CL     = ns_to_cyc(CONV_LOW_NS, CLK_NS);
  localparam int unsigned CYC_CL_MAX = CONV_LOW_MAX_NS / CLK_NS;
  localparam int unsigned CYC_RD     = ns_to_cyc(RD_ACCESS_NS, CLK_NS);
  localparam int unsigned CYC_ACQ    = ns_to_cyc(ACQ_NS, CLK_NS);
  localparam int unsigned CYC_WAKE   = ns_to_cyc(WAKE_NS, CLK_NS);
  localparam int unsigned CYC_TO     = ns_to_cyc(BUSY_TO_NS, CLK_NS);
  localparam int unsigned CNT_W      = $clog2(CYC_TO + CYC_WAKE + CYC_ACQ + CYC_RD + 2) + 1;

  logic             tmr_load, tmr_zero, push, bip_lat, hold_full;
  logic [CNT_W-1:0] tmr_val;

  adc_seq_timer #(.CNT_W(CNT_W), .RST_VAL(CYC_WAKE - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  adc_seq_ctrl #(
    .CNT_W(CNT_W), .CYC_CS(CYC_CS), .CYC_CL(CYC_CL), .CYC_CL_MAX(CYC_CL_MAX),
    .CYC_RD(CYC_RD), .CYC_ACQ(CYC_ACQ), .CYC_WAKE(CYC_WAKE), .CYC_TO(CYC_TO)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_valid_i(start_valid_i), .start_ready_o(start_ready_o),
    .mode_i(mode_i), .bip_i(bipolar_i), .sleep_req_i(sleep_req_i),
    .hold_full_i(hold_full), .busy_n_i(adc_busy_n_i),
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .push_o(push), .bip_o(bip_lat), .err_o(err_o),
    .cs_n_o(adc_cs_n_o), .rd_n_o(adc_rd_n_o),
    .convst_n_o(adc_convst_n_o), .shdn_n_o(adc_shdn_n_o)
  );

  adc_result_hold #(.RAW_W(DATA_W), .OUT_W(OUT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .push_i(push), .raw_i(adc_data_i), .bip_i(bip_lat),
    .out_ready_i(res_ready_i), .out_valid_o(hold_full), .out_data_o(res_data_o)
  );

  assign res_valid_o = hold_full;
endmodule

// File: tb/adc_read_seq_test.sv
module adc_read_seq_test;
  localparam int CLK_NS = 8;
  localparam int CS_C  = (20 + CLK_NS - 1) / CLK_NS;
  localparam int CL_C  = (40 + CLK_NS - 1) / CLK_NS;
  localparam int RD_C  = (170 + CLK_NS - 1) / CLK_NS;
  localparam int ACQ_C = (200 + CLK_NS - 1) / CLK_NS;
  localparam int WK_C  = (350 + CLK_NS - 1) / CLK_NS;
  localparam int TO_C  = (2600 + CLK_NS - 1) / CLK_NS;
  localparam int CONV_C = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_valid = 0, mode = 0, bip = 0, sleep_req = 0, res_ready = 1;
  logic start_ready, res_valid, err, cs_n, rd_n, convst_n, shdn_n;
  logic [15:0] res_data;
  logic busy_n = 1'b1;
  logic [11:0] out_latch = 12'h000, conv_sample = 12'h000;
  logic [11:0] adc_data;
  bit dead = 0;
  int n_cmp = 0, n_bad = 0, cycles = 0;

  always #(CLK_NS/2) clk = ~clk;

  assign adc_data = (!cs_n && !rd_n) ? out_latch : 12'h000;

  adc_read_seq uut (
    .clk(clk), .rst_n(rst_n), .start_valid_i(start_valid), .start_ready_o(start_ready),
    .mode_i(mode), .bipolar_i(bip), .sleep_req_i(sleep_req),
    .res_valid_o(res_valid), .res_ready_i(res_ready), .res_data_o(res_data), .err_o(err),
    .adc_cs_n_o(cs_n), .adc_rd_n_o(rd_n), .adc_convst_n_o(convst_n), .adc_shdn_n_o(shdn_n),
    .adc_busy_n_i(busy_n), .adc_data_i(adc_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
    end
  endtask

  // Converter model: BUSY low for CONV_C cycles after a selected falling convert-start
  bit conv_act = 0, prev_cv = 1;
  int conv_left = 0;
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      busy_n = 1; conv_act = 0; prev_cv = 1;
    end else begin
      if (conv_act) begin
        if (conv_left == 1) begin conv_act = 0; busy_n = 1; out_latch = conv_sample; end
        else conv_left--;
      end else if (!dead && prev_cv && !convst_n && !cs_n && shdn_n) begin
        conv_act = 1; conv_left = CONV_C; busy_n = 0;
      end
      prev_cv = convst_n;
    end
  end

  // Behavioural reference: phase names 0 idle,1 setup,2 start-low,3 wait,4 read,5 gap,6 sleep,7 wake
  int ph = 7, left = WK_C - 1;
  bit seen = 0, mm = 0, mb = 0, m_err = 0, m_valid = 0;
  logic [15:0] m_data = 16'h0;

  function automatic logic [15:0] widen(input logic [11:0] d, input bit b);
    return b ? {{4{d[11]}}, d} : {4'h0, d};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 7; left = WK_C - 1; seen = 0; mm = 0; mb = 0; m_err = 0; m_valid = 0; m_data = 0;
    end else begin
      automatic int  oph   = ph;
      automatic bit  held  = m_valid;
      automatic bit  rise  = (ph == 3) && seen && busy_n;
      automatic bit  expired = (left == 0);
      if (!expired) left--;
      if (m_valid && res_ready) m_valid = 0;
      case (oph)
        0: if (sleep_req) ph = 6;
           else if (start_valid && !held) begin
             ph = 1; left = CS_C - 1; mm = mode; mb = bip; seen = 0;
           end
        1: if (expired) begin ph = 2; left = CL_C - 1; end
        2: if (expired) begin ph = 3; left = TO_C - 1; end
        3: if (rise) begin
             if (!mm) begin m_valid = 1; m_data = widen(adc_data, mb); ph = 5; left = ACQ_C - 1; end
             else begin ph = 4; left = RD_C - 1; end
           end else if (expired) begin m_err = 1; ph = 0; end
        4: if (expired) begin m_valid = 1; m_data = widen(adc_data, mb); ph = 5; left = ACQ_C - 1; end
        5: if (expired) ph = 0;
        6: if (!sleep_req) begin ph = 7; left = WK_C - 1; end
        7: if (expired) ph = 0;
        default: ph = 0;
      endcase
      if ((oph == 2 || oph == 3) && !busy_n && !(oph == 0)) seen = 1;
    end
  end

  // Per-cycle comparison against the reference plus interval monitors
  int cs_low = 0, cv_low = 0, sh_high = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit sel   = (ph >= 1 && ph <= 4);
      automatic bit e_cs  = !sel;
      automatic bit e_rd  = !((sel && ph != 4 && !mm) || ph == 4);
      automatic bit e_cv  = (ph != 2);
      automatic bit e_sh  = (ph != 6);
      automatic bit e_sr  = (ph == 0) && !m_valid && !sleep_req;
      chk(cs_n == e_cs, "R2 chip select", cs_n, e_cs);
      chk(rd_n == e_rd, mm ? "R5 read strobe" : "R4 read held", rd_n, e_rd);
      chk(convst_n == e_cv, "R3 convert-start", convst_n, e_cv);
      chk(shdn_n == e_sh, "R9 power-down", shdn_n, e_sh);
      chk(start_ready == e_sr, "R6 start_ready", start_ready, e_sr);
      chk(res_valid == m_valid, "R8 res_valid", res_valid, m_valid);
      if (m_valid) chk(res_data == m_data, "R7 res_data", res_data, m_data);
      chk(err == m_err, "R10 err", err, m_err);
      // interval monitors
      if (!convst_n && cv_low == 0) begin
        chk(cs_low >= CS_C, "R2 setup cycles", cs_low, CS_C);
        chk(sh_high >= WK_C, "R9 wake cycles", sh_high, WK_C);
      end
      if (convst_n && cv_low != 0) chk(cv_low == CL_C, "R3 low width", cv_low, CL_C);
      cs_low  = cs_n ? 0 : cs_low + 1;
      cv_low  = convst_n ? 0 : cv_low + 1;
      sh_high = shdn_n ? sh_high + 1 : 0;
    end
  end

  task automatic conv_once(input bit md, input bit bp, input logic [11:0] smp,
                           input logic [15:0] exp, input string tag, input bit flip);
    int k;
    mode = md; bip = bp; conv_sample = smp;
    @(posedge clk); #1 start_valid = 1;
    do @(negedge clk); while (!start_ready);
    @(posedge clk); #1 start_valid = 0;
    if (flip) begin mode = !md; bip = !bp; end
    k = 0;
    do begin @(negedge clk); k++; end while (!res_valid && k < 2000);
    chk(res_data == exp, tag, res_data, exp);
    if (flip) begin mode = md; bip = bp; end
    @(posedge clk); #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=%0d cycles expected<150000", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(shdn_n && cs_n && rd_n && convst_n, "R1 pins idle", {cs_n, rd_n, convst_n, shdn_n}, 4'hF);
    chk(!res_valid && !err, "R1 flags clear", {res_valid, err}, 0);
    chk(!start_ready, "R1 ready held during wake", start_ready, 0);
    repeat (WK_C + 2) @(negedge clk);
    chk(start_ready, "R1 ready after wake", start_ready, 1);

    // R4 / R7 capture on BUSY, unipolar
    conv_once(0, 0, 12'h000, 16'h0000, "R4 unipolar zero", 0);
    conv_once(0, 0, 12'hFFF, 16'h0FFF, "R7 unipolar full", 0);
    conv_once(0, 1, 12'hA5C, 16'hFA5C, "R7 bipolar negative on busy mode", 0);
    // R5 / R7 strobed read, bipolar
    conv_once(1, 1, 12'h800, 16'hF800, "R5 strobed most negative", 0);
    conv_once(1, 1, 12'h7FF, 16'h07FF, "R7 bipolar most positive", 0);
    conv_once(1, 0, 12'h801, 16'h0801, "R5 strobed unipolar", 0);
    // R11: controls flipped during the conversion are ignored
    conv_once(1, 1, 12'h9AB, 16'hF9AB, "R11 flip after accept", 1);
    conv_once(0, 0, 12'h8C3, 16'h08C3, "R11 flip after accept busy mode", 1);

    // R8: back-pressure
    res_ready = 0;
    mode = 0; bip = 0; conv_sample = 12'h3C4;
    @(posedge clk); #1 start_valid = 1;
    do @(negedge clk); while (!start_ready);
    @(posedge clk); #1;
    begin
      int k = 0;
      do begin @(negedge clk); k++; end while (!res_valid && k < 2000);
    end
    repeat (60) @(negedge clk);
    chk(res_valid && res_data == 16'h03C4, "R8 result held", res_data, 16'h03C4);
    chk(!start_ready && cs_n, "R8 no new start while held", {start_ready, cs_n}, 2'b01);
    @(posedge clk); #1 start_valid = 0; res_ready = 1;
    @(posedge clk); #1;

    // R9: power-down while idle, then immediate start after release
    repeat (ACQ_C + 4) @(posedge clk);
    #1 sleep_req = 1;
    repeat (30) @(negedge clk);
    chk(!shdn_n && !start_ready, "R9 parked", {shdn_n, start_ready}, 0);
    @(posedge clk); #1 sleep_req = 0;
    conv_once(0, 1, 12'h001, 16'h0001, "R9 start after wake", 0);

    // R10: silent converter
    dead = 1;
    repeat (ACQ_C + 4) @(posedge clk);
    #1 start_valid = 1;
    do @(negedge clk); while (!start_ready);
    @(posedge clk); #1 start_valid = 0;
    begin
      int k = 0;
      do begin @(negedge clk); k++; end while (!err && k < 2000);
    end
    chk(err, "R10 timeout flag", err, 1);
    chk(!res_valid && cs_n, "R10 no result, deselected", {res_valid, cs_n}, 2'b01);
    dead = 0;
    conv_once(1, 0, 12'h456, 16'h0456, "R10 recovers after timeout", 0);
    chk(err, "R10 flag sticky", err, 1);

    repeat (40) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule